// File: doc/BRIEF.md
# SPI Master Controller with Transmit and Receive FIFOs

This block is a register-programmed SPI master that sits on a simple single-cycle memory-mapped bus. Software pushes bytes into a 32-entry transmit FIFO, chooses a transfer mode and a frame count, sets an even clock divider and then sets the run bit. The block shifts exactly the programmed number of 8-bit frames, most significant bit first, in SPI mode 0, and then goes back to idle. Received frames collect in a 32-entry receive FIFO, and software pops them by reading the receive data register.

Chip select is not driven by the transfer engine. A software bit drives it, so one chip-select window can cover any number of transfers. The engine stalls the serial clock at a frame boundary when it has no data to send or no room to store what it receives. It carries on once software services the FIFO. Clearing the run bit aborts a transfer at once.

Register map (word addresses on `bus_addr`): 0 mode, 1 frame count, 2 baud divider, 3 run, 4 chip select, 5 status, 6 transmit data, 7 receive data, 8 transmit level threshold, 9 receive level threshold.

Top module: `spi_master_fifo`

## Requirements
- R1: After reset the status register (address 5) reads 3'b100 (bit 0 busy = 0, bit 1 transmit-full = 0, bit 2 receive-empty = 1), `sclk` is low, `cs_n` is high, and the threshold registers (addresses 8 and 9) both read 15.
- R2: Writing 1 to bit 0 of address 4 drives `cs_n` low. It stays low across frames and across successive transfers until software writes 0.
- R3: With frame count C at address 1, a transfer produces exactly C+1 frames of 8 rising `sclk` edges each, and then busy clears.
- R4: Frames are MSB first in SPI mode 0. `sclk` idles low, `mosi` holds steady while `sclk` is high and changes only after a falling edge, and `miso` is sampled on the rising edge.
- R5: The `sclk` high and low phases each last floor(D/2) clock cycles for divider D at address 2, so bit 0 of D is ignored. A value below 2 acts as 2. The first rising edge of each frame comes one half period after the frame starts.
- R6: Mode value 1 at address 0 (send only) shifts out transmit data and stores no received frame.
- R7: Mode value 2 (receive only) drives `mosi` low for the whole transfer, takes nothing from the transmit FIFO, and stores every received frame. Mode values 0 and 3 send and receive together.
- R8: Writes to the mode, frame count and divider registers are ignored while the run bit (address 3, bit 0) is 1. Writing 1 to the run bit while it is 0 starts a transfer.
- R9: Writing 0 to the run bit during a transfer aborts it. Busy reads 0 in the next bus cycle, and `sclk` returns low.
- R10: Each FIFO holds 32 entries. Status bit 1 is set once 32 entries are queued, and a write to address 6 while the FIFO is full is dropped.
- R11: At a frame boundary the engine holds `sclk` low while it needs transmit data and the transmit FIFO is empty, or needs to store a frame and the receive FIFO is full. It resumes once the FIFO is serviced.
- R12: A read of address 7 returns the oldest received frame and removes it from the FIFO. A write to address 6 appends one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | 1 | Active-low chip select |

## Verification
Register writes take effect at the clock edge that ends the access, and status and receive data are visible combinationally in the read cycle itself. A receive pop takes effect at the edge that ends the read. An abort clears busy at the next edge, and serial edges follow every floor(D/2) cycles once a frame starts. The bench drives the bus just after each falling clock edge and samples `bus_rdata` one time unit later, inside the same access. It counts `sclk` edges with its own edge counters, so each expected frame count, bit and half-period width is taken from a fixed point rather than guessed in absolute cycles.

// File: rtl/spi_mst_pkg.sv
// Package: shared types and the register address map of the SPI master.
// Assumes a 4-bit word address on the register bus.
package spi_mst_pkg;

    localparam logic [3:0] ADR_MODE   = 4'd0;
    localparam logic [3:0] ADR_FRAMES = 4'd1;
    localparam logic [3:0] ADR_BAUD   = 4'd2;
    localparam logic [3:0] ADR_RUN    = 4'd3;
    localparam logic [3:0] ADR_SELECT = 4'd4;
    localparam logic [3:0] ADR_STATUS = 4'd5;
    localparam logic [3:0] ADR_TXD    = 4'd6;
    localparam logic [3:0] ADR_RXD    = 4'd7;
    localparam logic [3:0] ADR_TXLVL  = 4'd8;
    localparam logic [3:0] ADR_RXLVL  = 4'd9;

    typedef enum logic [1:0] {
        XFER_DUPLEX = 2'd0,
        XFER_SEND   = 2'd1,
        XFER_RECV   = 2'd2,
        XFER_ALT    = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOAD = 2'd1,
        ENG_RUN  = 2'd2
    } eng_state_e;

endpackage

// File: rtl/spi_fifo.sv
// Module: synchronous FIFO for SPI frames.
// Does: stores up to DEPTH words. A push while full and a pop while empty are dropped.
// Assumes: DEPTH is a power of two; the head word is shown combinationally.
module spi_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] fill;
    logic             push_ok, pop_ok;

    assign full_o  = (fill == CNT_W'(DEPTH));
    assign empty_o = (fill == '0);
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign head_o  = mem[rd_ptr];

    // Purpose: write the storage array on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data_i;
    end

    // Purpose: move the pointers and the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      fill <= fill + 1'b1;
            else if (pop_ok && !push_ok) fill <= fill - 1'b1;
        end
    end

    // R10: a push into a full FIFO without a pop leaves the level unchanged.
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> full_o);

    // R10: the fill level never goes past the depth.
    assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

endmodule

// File: rtl/spi_shift_engine.sv
// Module: SPI mode-0 frame engine.
// Does: runs (last_idx_i + 1) frames of FRAME_W bits, MSB first. Each sclk phase lasts
//       half_i clocks. At a frame boundary it waits for transmit data or receive room.
// Assumes: configuration inputs stay stable while busy_o is high; half_i >= 1.
module spi_shift_engine
    import spi_mst_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int CNT_W   = 16,
    parameter int DIV_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               abort_i,
    input  logic               use_tx_i,
    input  logic               use_rx_i,
    input  logic [CNT_W-1:0]   last_idx_i,
    input  logic [DIV_W-1:0]   half_i,
    input  logic               tx_empty_i,
    input  logic [FRAME_W-1:0] tx_data_i,
    output logic               tx_pop_o,
    input  logic               rx_full_i,
    output logic               rx_push_o,
    output logic [FRAME_W-1:0] rx_data_o,
    output logic               busy_o,
    output logic               sclk_o,
    output logic               mosi_o,
    input  logic               miso_i
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    eng_state_e         state;
    logic [CNT_W-1:0]   left;
    logic [DIV_W-1:0]   tick_cnt;
    logic [BIT_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] tx_sh, rx_sh;
    logic               frame_ok, tick, frame_end;

    assign frame_ok  = (!use_tx_i || !tx_empty_i) && (!use_rx_i || !rx_full_i);
    assign tick      = (tick_cnt == half_i - DIV_W'(1));
    assign frame_end = (state == ENG_RUN) && tick && sclk_o && (bit_idx == LAST_BIT);

    assign tx_pop_o  = (state == ENG_LOAD) && frame_ok && use_tx_i && !abort_i;
    assign rx_push_o = frame_end && use_rx_i && !abort_i;
    assign rx_data_o = rx_sh;
    assign busy_o    = (state != ENG_IDLE);
    assign mosi_o    = (state == ENG_RUN) ? tx_sh[FRAME_W-1] : 1'b0;

    // Purpose: sequence frames, generate sclk and shift data in and out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            left     <= '0;
            tick_cnt <= '0;
            bit_idx  <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            sclk_o   <= 1'b0;
        end else if (abort_i) begin
            state  <= ENG_IDLE;
            sclk_o <= 1'b0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start_i) begin
                        state <= ENG_LOAD;
                        left  <= last_idx_i;
                    end
                end
                ENG_LOAD: begin
                    if (frame_ok) begin
                        tx_sh    <= use_tx_i ? tx_data_i : '0;
                        tick_cnt <= '0;
                        bit_idx  <= '0;
                        state    <= ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    if (!tick) begin
                        tick_cnt <= tick_cnt + DIV_W'(1);
                    end else begin
                        tick_cnt <= '0;
                        if (!sclk_o) begin
                            sclk_o <= 1'b1;
                            rx_sh  <= {rx_sh[FRAME_W-2:0], miso_i};
                        end else begin
                            sclk_o <= 1'b0;
                            if (bit_idx == LAST_BIT) begin
                                if (left == '0) begin
                                    state <= ENG_IDLE;
                                end else begin
                                    left  <= left - CNT_W'(1);
                                    state <= ENG_LOAD;
                                end
                            end else begin
                                bit_idx <= bit_idx + BIT_W'(1);
                                tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R4: sclk idles low whenever the engine is not busy.
    assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);

    // R4: mosi does not move while sclk stays high.
    assert_mosi_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> (mosi_o == $past(mosi_o)));

    // R7: nothing but zero goes out when the transmit side is unused.
    assert_recv_mosi_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !use_tx_i) |-> !mosi_o);

    // R6: no frame is stored when the receive side is unused.
    assert_send_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !use_rx_i |-> !rx_push_o);

    // R11: no clock edge while waiting at a frame boundary.
    assert_stall_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_LOAD && !frame_ok && !abort_i) |=> !sclk_o);

endmodule

// File: rtl/spi_master_fifo.sv
// Module: register-programmed SPI master with transmit and receive FIFOs (top).
// Does: decodes the register bus, holds the configuration, drives chip select from a
//       software bit and connects both FIFOs to the frame engine.
// Assumes: one-cycle bus accesses; bus_rdata is valid in the access cycle.
module spi_master_fifo
    import spi_mst_pkg::*;
#(
    parameter int FRAME_W    = 8,
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 16,
    parameter int BUS_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    localparam int LVL_W = $clog2(FIFO_DEPTH);
    localparam logic [LVL_W-1:0] LVL_RESET = LVL_W'(FIFO_DEPTH / 2 - 1);

    xfer_mode_e         mode_q;
    logic [CNT_W-1:0]   frames_q;
    logic [DIV_W-1:0]   baud_q, half;
    logic               run_q, sel_q;
    logic [LVL_W-1:0]   tx_lvl_q, rx_lvl_q;
    logic               wr, rd, cfg_open, start, abort;
    logic               use_tx, use_rx;
    logic               tx_full, tx_empty, tx_pop, tx_push;
    logic               rx_full, rx_empty, rx_pop, rx_push;
    logic [FRAME_W-1:0] tx_head, rx_head, rx_word;
    logic               busy;

    assign wr       = bus_en && bus_we;
    assign rd       = bus_en && !bus_we;
    assign cfg_open = !run_q;
    assign start    = wr && (bus_addr == ADR_RUN) && bus_wdata[0] && !run_q;
    assign abort    = wr && (bus_addr == ADR_RUN) && !bus_wdata[0] && run_q;
    assign tx_push  = wr && (bus_addr == ADR_TXD);
    assign rx_pop   = rd && (bus_addr == ADR_RXD);
    assign use_tx   = (mode_q != XFER_RECV);
    assign use_rx   = (mode_q != XFER_SEND);
    assign half     = ((baud_q >> 1) == '0) ? DIV_W'(1) : (baud_q >> 1);
    assign cs_n     = !sel_q;

    // Purpose: hold the configuration, run and chip-select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= XFER_DUPLEX;
            frames_q <= '0;
            baud_q   <= DIV_W'(2);
            run_q    <= 1'b0;
            sel_q    <= 1'b0;
            tx_lvl_q <= LVL_RESET;
            rx_lvl_q <= LVL_RESET;
        end else if (wr) begin
            unique case (bus_addr)
                ADR_MODE:   if (cfg_open) mode_q <= xfer_mode_e'(bus_wdata[1:0]);
                ADR_FRAMES: if (cfg_open) frames_q <= bus_wdata[CNT_W-1:0];
                ADR_BAUD:   if (cfg_open) baud_q <= bus_wdata[DIV_W-1:0];
                ADR_RUN:    run_q <= bus_wdata[0];
                ADR_SELECT: sel_q <= bus_wdata[0];
                ADR_TXLVL:  tx_lvl_q <= bus_wdata[LVL_W-1:0];
                ADR_RXLVL:  rx_lvl_q <= bus_wdata[LVL_W-1:0];
                default:    ;
            endcase
        end
    end

    // Purpose: return register contents for the addressed read.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_MODE:   bus_rdata = BUS_W'(mode_q);
            ADR_FRAMES: bus_rdata = BUS_W'(frames_q);
            ADR_BAUD:   bus_rdata = BUS_W'(baud_q);
            ADR_RUN:    bus_rdata = BUS_W'(run_q);
            ADR_SELECT: bus_rdata = BUS_W'(sel_q);
            ADR_STATUS: bus_rdata = BUS_W'({rx_empty, tx_full, busy});
            ADR_RXD:    bus_rdata = BUS_W'(rx_head);
            ADR_TXLVL:  bus_rdata = BUS_W'(tx_lvl_q);
            ADR_RXLVL:  bus_rdata = BUS_W'(rx_lvl_q);
            default:    bus_rdata = '0;
        endcase
    end

    spi_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (tx_push),
        .push_data_i (bus_wdata[FRAME_W-1:0]),
        .pop_i       (tx_pop),
        .head_o      (tx_head),
        .full_o      (tx_full),
        .empty_o     (tx_empty)
    );

    spi_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (rx_push),
        .push_data_i (rx_word),
        .pop_i       (rx_pop),
        .head_o      (rx_head),
        .full_o      (rx_full),
        .empty_o     (rx_empty)
    );

    spi_shift_engine #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .abort_i    (abort),
        .use_tx_i   (use_tx),
        .use_rx_i   (use_rx),
        .last_idx_i (frames_q),
        .half_i     (half),
        .tx_empty_i (tx_empty),
        .tx_data_i  (tx_head),
        .tx_pop_o   (tx_pop),
        .rx_full_i  (rx_full),
        .rx_push_o  (rx_push),
        .rx_data_o  (rx_word),
        .busy_o     (busy),
        .sclk_o     (sclk),
        .mosi_o     (mosi),
        .miso_i     (miso)
    );

    // R8: frame count is frozen while the run bit is set.
    assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && wr && bus_addr == ADR_FRAMES) |=> (frames_q == $past(frames_q)));

    // R9: an abort leaves the engine idle one cycle later.
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

    // R2: chip select follows only the select register, not the engine.
    assert_cs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && bus_addr == ADR_SELECT) |=> (cs_n == $past(cs_n)));

endmodule

// File: tb/spi_master_fifo_tb.sv
// Bench: random byte data from a fixed seed plus directed corner cases, with a bench
// slave model on the serial pins and expected values from bench functions.
module spi_master_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BITBUF     = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk, mosi, miso, cs_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int rise_cnt = 0, fall_cnt = 0, rise_base = 0, fall_base = 0;
    int clk_cyc = 0, t_rise = 0, hi_w = 0;
    logic [7:0] salt = 8'h00;
    logic       mosi_bits [BITBUF];
    logic [7:0] sent [64];

    spi_master_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) clk_cyc <= clk_cyc + 1;

    function automatic logic [7:0] slave_byte(int k);
        return 8'(k * 37) + 8'hC3 + salt;
    endfunction

    function automatic int exp_half(int d);
        return ((d >> 1) == 0) ? 1 : (d >> 1);
    endfunction

    // Slave model: mode 0, bit index advances on each falling sclk edge.
    assign miso = slave_byte((fall_cnt - fall_base) / 8)[7 - ((fall_cnt - fall_base) % 8)];

    always @(posedge sclk) begin
        mosi_bits[rise_cnt % BITBUF] = mosi;
        rise_cnt = rise_cnt + 1;
        t_rise   = clk_cyc;
    end
    always @(negedge sclk) begin
        fall_cnt = fall_cnt + 1;
        hi_w     = clk_cyc - t_rise;
    end

    function automatic logic [7:0] mosi_byte(int k);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7-i] = mosi_bits[(rise_base + 8*k + i) % BITBUF];
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup_xfer(input int mode, input int cnt, input int div);
        bus_wr(4'd3, 16'd0);
        bus_wr(4'd0, 16'(mode));
        bus_wr(4'd1, 16'(cnt));
        bus_wr(4'd2, 16'(div));
        rise_base = rise_cnt;
        fall_base = fall_cnt;
        salt      = 8'($urandom);
    endtask

    task automatic wait_idle(input int limit);
        logic [15:0] s;
        for (int i = 0; i < limit; i++) begin
            bus_rd(4'd5, s);
            if (!s[0]) return;
        end
    endtask

    task automatic push_random(input int n);
        for (int i = 0; i < n; i++) begin
            sent[i % 64] = 8'($urandom);
            bus_wr(4'd6, 16'(sent[i % 64]));
        end
    endtask

    task automatic read_rx(input int n, input int first, input string req);
        logic [15:0] d;
        for (int i = 0; i < n; i++) begin
            bus_rd(4'd7, d);
            check(d[7:0] == slave_byte(first + i), req, "rx byte", int'(d[7:0]),
                  int'(slave_byte(first + i)));
        end
    endtask

    initial begin
        logic [15:0] s;
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        bus_rd(4'd5, s);
        check(s[2:0] == 3'b100, "R1", "status after reset", int'(s[2:0]), 4);
        check(sclk == 1'b0, "R1", "sclk after reset", int'(sclk), 0);
        check(cs_n == 1'b1, "R1", "cs_n after reset", int'(cs_n), 1);
        bus_rd(4'd8, s);
        check(s == 16'd15, "R1", "tx threshold", int'(s), 15);
        bus_rd(4'd9, s);
        check(s == 16'd15, "R1", "rx threshold", int'(s), 15);

        // R2: chip select by software bit
        bus_wr(4'd4, 16'd1);
        check(cs_n == 1'b0, "R2", "cs_n asserted", int'(cs_n), 0);

        // R3 R4 R5 R12: duplex, 4 frames, divider 4
        push_random(4);
        setup_xfer(0, 3, 4);
        bus_wr(4'd3, 16'd1);
        wait_idle(500);
        check(rise_cnt - rise_base == 32, "R3", "duplex rising edges", rise_cnt - rise_base, 32);
        for (int k = 0; k < 4; k++)
            check(mosi_byte(k) == sent[k], "R4", "duplex mosi byte", int'(mosi_byte(k)), int'(sent[k]));
        check(hi_w == exp_half(4), "R5", "high width div 4", hi_w, exp_half(4));
        read_rx(4, 0, "R12");
        bus_rd(4'd5, s);
        check(s[2] == 1'b1, "R12", "rx empty after pops", int'(s[2]), 1);
        check(cs_n == 1'b0, "R2", "cs_n held after transfer", int'(cs_n), 0);

        // R6 R5: send only, odd divider 7
        push_random(3);
        setup_xfer(1, 2, 7);
        bus_wr(4'd3, 16'd1);
        wait_idle(500);
        check(rise_cnt - rise_base == 24, "R3", "send-only edges", rise_cnt - rise_base, 24);
        for (int k = 0; k < 3; k++)
            check(mosi_byte(k) == sent[k], "R6", "send-only mosi byte", int'(mosi_byte(k)), int'(sent[k]));
        check(hi_w == exp_half(7), "R5", "high width div 7", hi_w, exp_half(7));
        bus_rd(4'd5, s);
        check(s[2] == 1'b1, "R6", "nothing stored", int'(s[2]), 1);

        // R7 R5: receive only with two bytes queued, divider 1
        push_random(2);
        setup_xfer(2, 1, 1);
        bus_wr(4'd3, 16'd1);
        wait_idle(500);
        check(rise_cnt - rise_base == 16, "R7", "recv-only edges", rise_cnt - rise_base, 16);
        for (int k = 0; k < 2; k++)
            check(mosi_byte(k) == 8'h00, "R7", "recv-only mosi", int'(mosi_byte(k)), 0);
        check(hi_w == 1, "R5", "high width div 1", hi_w, 1);
        read_rx(2, 0, "R7");
        setup_xfer(1, 1, 2);
        bus_wr(4'd3, 16'd1);
        wait_idle(500);
        for (int k = 0; k < 2; k++)
            check(mosi_byte(k) == sent[k], "R7", "tx fifo untouched", int'(mosi_byte(k)), int'(sent[k]));

        // R11 R8: stall on empty tx, config write while running ignored
        setup_xfer(0, 1, 2);
        bus_wr(4'd3, 16'd1);
        idle(40);
        check(rise_cnt == rise_base, "R11", "no sclk while tx empty", rise_cnt - rise_base, 0);
        bus_rd(4'd5, s);
        check(s[0] == 1'b1, "R11", "busy while stalled", int'(s[0]), 1);
        bus_wr(4'd1, 16'd5);
        bus_rd(4'd1, s);
        check(s == 16'd1, "R8", "frame count locked", int'(s), 1);
        push_random(2);
        wait_idle(500);
        check(rise_cnt - rise_base == 16, "R8", "frames after locked write", rise_cnt - rise_base, 16);
        read_rx(2, 0, "R11");

        // R9: abort mid transfer
        setup_xfer(2, 9, 4);
        bus_wr(4'd3, 16'd1);
        idle(30);
        bus_wr(4'd3, 16'd0);
        bus_rd(4'd5, s);
        check(s[0] == 1'b0, "R9", "busy after abort", int'(s[0]), 0);
        check(sclk == 1'b0, "R9", "sclk after abort", int'(sclk), 0);
        for (int i = 0; i < 12; i++) begin
            bus_rd(4'd5, s);
            if (s[2]) break;
            bus_rd(4'd7, s);
        end
        bus_rd(4'd5, s);
        check(s[2] == 1'b1, "R9", "rx drained", int'(s[2]), 1);

        // R10: depth 32, 33rd push dropped
        push_random(33);
        bus_rd(4'd5, s);
        check(s[1] == 1'b1, "R10", "tx full flag", int'(s[1]), 1);
        setup_xfer(0, 31, 2);
        bus_wr(4'd3, 16'd1);
        wait_idle(2000);
        check(rise_cnt - rise_base == 256, "R10", "32 frames edges", rise_cnt - rise_base, 256);
        for (int k = 0; k < 32; k++)
            check(mosi_byte(k) == sent[k], "R10", "depth mosi byte", int'(mosi_byte(k)), int'(sent[k]));
        read_rx(32, 0, "R10");
        setup_xfer(1, 0, 2);
        bus_wr(4'd3, 16'd1);
        idle(30);
        check(rise_cnt == rise_base, "R10", "33rd entry dropped", rise_cnt - rise_base, 0);
        bus_wr(4'd3, 16'd0);

        // R11: stall on full rx
        setup_xfer(2, 32, 2);
        bus_wr(4'd3, 16'd1);
        idle(800);
        check(rise_cnt - rise_base == 256, "R11", "stalled on rx full", rise_cnt - rise_base, 256);
        bus_rd(4'd5, s);
        check(s[0] == 1'b1, "R11", "busy while rx full", int'(s[0]), 1);
        read_rx(1, 0, "R11");
        idle(100);
        bus_rd(4'd5, s);
        check(s[0] == 1'b0, "R11", "resumed and done", int'(s[0]), 0);
        check(rise_cnt - rise_base == 264, "R3", "33 frames total", rise_cnt - rise_base, 264);
        read_rx(32, 1, "R11");

        // R2: release chip select
        check(cs_n == 1'b0, "R2", "cs_n still held", int'(cs_n), 0);
        bus_wr(4'd4, 16'd0);
        check(cs_n == 1'b1, "R2", "cs_n released", int'(cs_n), 1);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule